// File: doc/BRIEF.md
# TDM Time-Slot Interchanger with Literal Message Output

This block moves bytes between time slots of serial TDM lines. It groups its serial pins in port pairs, and each pair has two input pins and two output pins. A pair runs in one of two rate modes. In the fast mode it carries one line of 64 slots on its first pins, and its second pins are not used. In the slow mode it carries two lines of 32 slots each, and each bit lasts two clock cycles. The clock is the fast bit clock, so one frame is 512 cycles long. A frame-sync pulse on the `fsync` input marks bit 0 of a frame. Bits travel most significant first.

Every received byte is written into a data memory that has two banks. Each frame writes one bank and reads the other, so an output frame always reads the complete input frame that came before it. For each output slot the block reads a connection-memory entry. In switching mode the entry addresses the data memory. In message mode the entry byte itself is transmitted. Connection memory is loaded through a simple write port.

Each pair also has its own drive-style control, which produces an output value and an output enable for every pin. In push-pull mode both levels are driven and an unused pin floats. In open-drain mode a 0 is pulled low and a 1 is released.

Top module: `tsi_switch`

## Requirements
- R1: When `msg_en`=1, each output slot carries the connection-memory entry of that slot, MSB first.
- R2: When `msg_en`=0, each output slot carries the data-memory byte addressed by the low 7 bits of the connection-memory entry. That byte is taken from the input frame that completed before the current frame began. During the first frame after reset, every byte read is 0.
- R3: With `rate4[p]`=1, pair p uses only pin 2p. It carries channels 0..63, with channel = position/8 and bit = position mod 8. Input pin 2p+1 is ignored, and output pin 2p+1 has its enable low.
- R4: With `rate4[p]`=0, pins 2p and 2p+1 each carry 32 slots. Each bit lasts 2 cycles. The channel is pin*32 + position/16, and the bit is (position/2) mod 8. Input is sampled in the second cycle of each bit.
- R5: The cycle in which `fsync` is high is frame position 0. The position then counts up by one each cycle and wraps from 511 to 0, and the data-memory banks swap at each wrap.
- R6: In push-pull mode (`od_mode[p]`=0), an active pin has `doe`=1 and `dout` equal to the bit. An inactive pin has `doe`=0 and `dout`=0.
- R7: In open-drain mode (`od_mode[p]`=1), `dout` is always 0 and `doe` is high exactly when an active pin sends 0.
- R8: The drive mode and rate mode of each pair are independent of those of the other pairs.
- R9: Synchronous reset clears both memories, the position counter and the bank select.
- R10: Memory addresses are {pair, channel}. The connection-memory entry for output channel c of pair p lives at address p*64+c, and input channel c of pair p is stored at data address p*64+c.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast bit clock |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | Frame pulse, marks position 0 |
| msg_en | input | 1 | 1: send connection entries literally; 0: switch |
| rate4 | input | NUM_PAIRS | Per pair: 1 = one 64-slot line, 0 = two 32-slot lines |
| od_mode | input | NUM_PAIRS | Per pair: 1 = open drain, 0 = push-pull |
| cm_we | input | 1 | Connection memory write strobe |
| cm_addr | input | ADDR_W (7) | Connection memory write address {pair, channel} |
| cm_wdata | input | 8 | Connection memory write data |
| din | input | 2*NUM_PAIRS | Serial inputs, pin 2p+k belongs to pair p |
| dout | output | 2*NUM_PAIRS | Serial output values |
| doe | output | 2*NUM_PAIRS | Serial output enables |

## Verification
Each fault in this block shows at the output pins within one frame. A wrong position count or a missed bank swap puts bytes from the wrong frame into the next output frame. A wrong rate or channel mapping swaps bytes between slots, or leaves the spare pin driven within the first slot. A wrong drive style shows in the same cycle as a driven 1 in open-drain mode or a floating active pin in push-pull mode. The bench predicts every pin in every cycle over frames that change the modes per pair, so these faults are caught in the frame in which they occur.

// File: rtl/tsi_pkg.sv
package tsi_pkg;

    localparam int SLOT_BITS   = 8;
    localparam int FRAME_SLOTS = 64;
    localparam int CHAN_W      = $clog2(FRAME_SLOTS);
    localparam int FRAME_LEN   = FRAME_SLOTS * SLOT_BITS;
    localparam int POS_W       = $clog2(FRAME_LEN);

    typedef logic [SLOT_BITS-1:0] byte_t;
    typedef logic [POS_W-1:0]     pos_t;
    typedef logic [CHAN_W-1:0]    chan_t;

    typedef enum logic {
        DRV_PUSHPULL  = 1'b0,
        DRV_OPENDRAIN = 1'b1
    } drv_e;

    typedef struct packed {
        logic  vld;
        chan_t chan;
        byte_t data;
    } dm_wr_t;

    // Channel within a pair for an output pin at a frame position
    function automatic chan_t slot_chan(logic fast, logic pin, pos_t pos);
        return fast ? pos[POS_W-1:3] : {pin, pos[POS_W-1:4]};
    endfunction

    // Bit number inside the slot byte, 0 = first sent (MSB)
    function automatic logic [2:0] slot_bit(logic fast, pos_t pos);
        return fast ? pos[2:0] : pos[3:1];
    endfunction

endpackage

// File: rtl/tsi_timing.sv
module tsi_timing
    import tsi_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic fsync,
    output pos_t pos,
    output logic wbank
);
    pos_t cnt;

    always_comb pos = fsync ? '0 : cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt   <= '0;
            wbank <= 1'b0;
        end else begin
            cnt <= pos + 1'b1;
            if (pos == pos_t'(FRAME_LEN - 1))
                wbank <= ~wbank;
        end
    end

    // R5: banks swap at each frame wrap
    p_bank_swap_r5: assert property (@(posedge clk) disable iff (rst)
        (pos == pos_t'(FRAME_LEN - 1)) |=> (wbank != $past(wbank)));

    // R5: mid-frame the bank stays put
    p_bank_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (pos != pos_t'(FRAME_LEN - 1)) |=> $stable(wbank));

endmodule

// File: rtl/tsi_rx.sv
module tsi_rx
    import tsi_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       fast,
    input  logic [1:0] din,
    input  pos_t       pos,
    output dm_wr_t     wr0,
    output dm_wr_t     wr1
);
    byte_t sr0, sr1;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr0 <= '0;
            sr1 <= '0;
        end else if (fast) begin
            sr0 <= {sr0[SLOT_BITS-2:0], din[0]};
        end else if (pos[0]) begin
            sr0 <= {sr0[SLOT_BITS-2:0], din[0]};
            sr1 <= {sr1[SLOT_BITS-2:0], din[1]};
        end
    end

    always_comb begin
        wr0.vld  = fast ? (pos[2:0] == 3'd7) : (pos[3:0] == 4'd15);
        wr0.chan = fast ? pos[POS_W-1:3] : {1'b0, pos[POS_W-1:4]};
        wr0.data = {sr0[SLOT_BITS-2:0], din[0]};
        wr1.vld  = !fast && (pos[3:0] == 4'd15);
        wr1.chan = {1'b1, pos[POS_W-1:4]};
        wr1.data = {sr1[SLOT_BITS-2:0], din[1]};
    end

    // R4: a line completes at most one byte every other cycle
    p_wr_spacing_r4: assert property (@(posedge clk) disable iff (rst)
        wr0.vld |=> !wr0.vld);

endmodule

// File: rtl/tsi_pindrv.sv
module tsi_pindrv
    import tsi_pkg::*;
(
    input  logic active,
    input  logic bitv,
    input  drv_e mode,
    output logic dout,
    output logic doe
);
    always_comb begin
        if (mode == DRV_OPENDRAIN) begin
            dout = 1'b0;
            doe  = active & ~bitv;
        end else begin
            dout = active & bitv;
            doe  = active;
        end
    end
endmodule

// File: rtl/tsi_switch.sv
module tsi_switch
    import tsi_pkg::*;
#(
    parameter int NUM_PAIRS = 2,
    parameter int PAIR_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
    parameter int ADDR_W    = PAIR_W + CHAN_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   fsync,
    input  logic                   msg_en,
    input  logic [NUM_PAIRS-1:0]   rate4,
    input  logic [NUM_PAIRS-1:0]   od_mode,
    input  logic                   cm_we,
    input  logic [ADDR_W-1:0]      cm_addr,
    input  logic [7:0]             cm_wdata,
    input  logic [2*NUM_PAIRS-1:0] din,
    output logic [2*NUM_PAIRS-1:0] dout,
    output logic [2*NUM_PAIRS-1:0] doe
);
    localparam int DEPTH = 1 << ADDR_W;

    pos_t   pos;
    logic   wbank;
    dm_wr_t wr0 [NUM_PAIRS];
    dm_wr_t wr1 [NUM_PAIRS];
    byte_t  dmem [2][DEPTH];
    byte_t  cmem [DEPTH];

    tsi_timing u_timing (
        .clk   (clk),
        .rst   (rst),
        .fsync (fsync),
        .pos   (pos),
        .wbank (wbank)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                cmem[i]    <= '0;
                dmem[0][i] <= '0;
                dmem[1][i] <= '0;
            end
        end else begin
            if (cm_we)
                cmem[cm_addr] <= cm_wdata;
            for (int p = 0; p < NUM_PAIRS; p++) begin
                if (wr0[p].vld)
                    dmem[wbank][{PAIR_W'(p), wr0[p].chan}] <= wr0[p].data;
                if (wr1[p].vld)
                    dmem[wbank][{PAIR_W'(p), wr1[p].chan}] <= wr1[p].data;
            end
        end
    end

    for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
        tsi_rx u_rx (
            .clk  (clk),
            .rst  (rst),
            .fast (rate4[p]),
            .din  (din[2*p +: 2]),
            .pos  (pos),
            .wr0  (wr0[p]),
            .wr1  (wr1[p])
        );

        for (genvar k = 0; k < 2; k++) begin : g_pin
            chan_t ch;
            byte_t entry, tx_byte;
            logic  active;

            always_comb begin
                ch      = slot_chan(rate4[p], k[0], pos);
                entry   = cmem[{PAIR_W'(p), ch}];
                tx_byte = msg_en ? entry : dmem[~wbank][entry[ADDR_W-1:0]];
                active  = !rate4[p] || (k == 0);
            end

            tsi_pindrv u_drv (
                .active (active),
                .bitv   (tx_byte[3'd7 - slot_bit(rate4[p], pos)]),
                .mode   (drv_e'(od_mode[p])),
                .dout   (dout[2*p+k]),
                .doe    (doe[2*p+k])
            );
        end

        // R3: spare pin of a fast pair never drives
        p_spare_idle_r3: assert property (@(posedge clk) disable iff (rst)
            rate4[p] |-> !doe[2*p+1]);

        // R7: open-drain pins never present a high level
        p_od_no_high_r7: assert property (@(posedge clk) disable iff (rst)
            od_mode[p] |-> (dout[2*p +: 2] == 2'b00));

        // R6: push-pull slow pair drives both pins
        p_pp_driven_r6: assert property (@(posedge clk) disable iff (rst)
            (!od_mode[p] && !rate4[p]) |-> (doe[2*p +: 2] == 2'b11));
    end

endmodule

// File: tb/tsi_switch_tb.sv
module tsi_switch_tb;
    localparam int NP = 2;
    localparam int AW = 7;
    localparam int NV = 8;
    // {msg_en, rate4[1:0], od_mode[1:0]} per frame
    localparam logic [4:0] VEC [NV] = '{
        5'b0_00_00, 5'b0_00_00, 5'b0_11_00, 5'b0_01_01,
        5'b1_00_00, 5'b1_10_10, 5'b0_10_11, 5'b0_00_11
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fsync = 1'b0;
    logic msg_en = 1'b0;
    logic [NP-1:0] rate4 = '0;
    logic [NP-1:0] od_mode = '0;
    logic cm_we = 1'b0;
    logic [AW-1:0] cm_addr = '0;
    logic [7:0] cm_wdata = '0;
    logic [2*NP-1:0] din = '0;
    logic [2*NP-1:0] dout, doe;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    tsi_switch u_dut (
        .clk(clk), .rst(rst), .fsync(fsync), .msg_en(msg_en),
        .rate4(rate4), .od_mode(od_mode), .cm_we(cm_we),
        .cm_addr(cm_addr), .cm_wdata(cm_wdata),
        .din(din), .dout(dout), .doe(doe)
    );

    function automatic logic [7:0] cm_pat(int a);
        return 8'((a * 53 + 17) & 255);
    endfunction

    function automatic logic [7:0] in_byte(int f, int a);
        return 8'((f * 29 + a * 7 + 3) & 255);
    endfunction

    // R3, R4, R10: stream bit driven on input pin k of pair p
    function automatic logic in_bit(int f, int p, int k, int pos, logic fast);
        logic [7:0] b;
        if (fast) begin
            if (k == 1) return logic'(((pos >> 3) ^ pos) & 1);
            b = in_byte(f, p * 64 + (pos >> 3));
            return b[7 - (pos % 8)];
        end
        b = in_byte(f, p * 64 + k * 32 + (pos >> 4));
        return b[7 - ((pos >> 1) % 8)];
    endfunction

    // returns {doe, dout}
    function automatic logic [1:0] exp_pin(int f, int p, int k, int pos,
                                           logic msg, logic fast, logic od);
        logic act, b;
        int ch, bi;
        logic [7:0] entry, by;
        act = !fast || (k == 0);
        ch  = fast ? (pos >> 3) : (k * 32 + (pos >> 4));
        bi  = fast ? (pos % 8) : ((pos >> 1) % 8);
        entry = cm_pat(p * 64 + ch);
        by = msg ? entry : ((f == 0) ? 8'h00 : in_byte(f - 1, entry % 128));
        b = by[7 - bi];
        return od ? {act & ~b, 1'b0} : {act, act & b};
    endfunction

    task automatic check(string req, logic [1:0] act, logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: {doe,dout} actual %b expected %b at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        #2;
        // R9: after reset, push-pull slow pairs drive zeros
        for (int i = 0; i < 2 * NP; i++)
            check("R9 reset", {doe[i], dout[i]}, 2'b10);

        // load connection memory, R10 addressing {pair, channel}
        for (int a = 0; a < NP * 64; a++) begin
            @(negedge clk);
            cm_we = 1'b1; cm_addr = AW'(a); cm_wdata = cm_pat(a);
        end
        @(negedge clk);
        cm_we = 1'b0;

        // vector walk: R1 R2 R3 R4 R5 R6 R7 R8 R10
        for (int f = 0; f < NV; f++) begin
            for (int pos = 0; pos < 512; pos++) begin
                @(negedge clk);
                fsync = (pos == 0);
                if (pos == 0) {msg_en, rate4, od_mode} = VEC[f];
                for (int p = 0; p < NP; p++)
                    for (int k = 0; k < 2; k++)
                        din[2*p+k] = in_bit(f, p, k, pos, rate4[p]);
                #2;
                for (int p = 0; p < NP; p++)
                    for (int k = 0; k < 2; k++)
                        check($sformatf("%s %s %s p%0d", msg_en ? "R1" : "R2",
                                        rate4[p] ? "R3" : "R4",
                                        od_mode[p] ? "R7" : "R6", p),
                              {doe[2*p+k], dout[2*p+k]},
                              exp_pin(f, p, k, pos, msg_en, rate4[p], od_mode[p]));
            end
        end

        // R9: reset mid-run clears connection memory (message mode sends 0)
        @(negedge clk);
        fsync = 1'b0; rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; msg_en = 1'b1; rate4 = '0; od_mode = 2'b01;
        #2;
        check("R9 R8 cleared cm p0", {doe[0], dout[0]}, 2'b10);
        check("R9 R8 cleared cm p1", {doe[2], dout[2]}, 2'b10);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule